// File: doc/BRIEF.md
# SD Card Multi-Block Data Engine

This block runs the data phase of an SD card transfer once the command phase is over. It moves one or more fixed-length blocks over the card's DAT lines. It can use DAT0 alone or all four lines, and it handles both directions. For reads it waits for each block's start bit and shifts the payload into 32-bit words. It runs a CRC16 on every active lane and compares the received checksum. For writes it waits a programmable number of idle clocks, then sends the start bit, the payload, one CRC16 per lane and the end bit. After that it collects the card's three-bit status token and waits for the card to release DAT0 before it goes on.

Software-facing logic sets the block length in bits, including the per-lane CRC allowance, and the block count minus one. It also sets the direction, the bus width, the idle gap before write data, the token value that means success, and an option that exchanges DAT0 and DAT1. The engine advances one bus bit per clock. Payload words leave and enter through a plain word interface. At the end, one of two status flags says whether every block's checksum, or every write token, was good.

Top module: `sd_block_mover`

## Requirements
- R1: After reset, busy, done, datOe, wordOutValid, wordInReady, readCrcOk and writeCrcOk are all 0.
- R2: A start pulse while idle begins a transfer of blockCountM1+1 blocks, so 1 to 256 blocks.
- R3: blockBits holds payload bits plus 15 times the lane count. Each block carries (blockBits − 15·L)/L payload clocks, then 16 CRC clocks, then one end-bit clock, where L is 1 or 4.
- R4: wideBus=0 uses only DAT0. wideBus=1 uses DAT3..DAT0. Words travel MSB first, and in 4-bit mode DAT3 carries the highest bit of each nibble.
- R5: On reads a block begins only when DAT0 is 0 (1-bit) or all four lanes are 0 (4-bit). Any other pattern is idle.
- R6: Each active lane has its own CRC16 (polynomial 0x1021, initial value 0), restarted every block. On writes it is sent MSB first right after the payload.
- R7: After a read, readCrcOk is 1 only if every received CRC bit on every active lane of every block matched. Both status flags clear when a transfer starts.
- R8: Before each written block the lines stay released for exactly gapClocks clocks, then a start bit of 0 is driven on the active lanes.
- R9: After the write end bit the engine releases the lines and waits for a 0 on DAT0. It takes the next three DAT0 bits, MSB first, as the status token, skips one end bit, and sets writeCrcOk at the end only if every token equalled expectToken.
- R10: After each token the engine holds while DAT0 is 0. Only after DAT0 reads 1 does it start the next block or finish.
- R11: laneSwap=1 exchanges physical DAT0 and DAT1 for input, output and enable alike.
- R12: done is a one-clock pulse on the edge that ends the last block, and busy falls on that same edge.
- R13: wordOutValid is high for one clock per received word, with wordOut stable in that clock. wordInReady marks each clock at whose end wordIn is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus bit per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (used while idle) |
| isWrite | input | 1 | 1 = write to card, 0 = read from card |
| wideBus | input | 1 | 0 = 1-bit bus, 1 = 4-bit bus |
| laneSwap | input | 1 | Exchange DAT0 and DAT1 |
| blockCountM1 | input | 8 | Number of blocks minus one |
| blockBits | input | 14 | Payload bits plus 15 per lane |
| gapClocks | input | 6 | Idle clocks before each written block |
| expectToken | input | 3 | Token value meaning write accepted |
| datIn | input | 4 | Sampled DAT lines |
| datOut | output | 4 | Driven DAT values |
| datOe | output | 4 | Per-lane output enable |
| wordIn | input | 32 | Next word to write |
| wordInReady | output | 1 | wordIn is taken at the end of this cycle |
| wordOut | output | 32 | Received word |
| wordOutValid | output | 1 | wordOut holds a new word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished pulse |
| readCrcOk | output | 1 | All read CRCs matched |
| writeCrcOk | output | 1 | All write tokens matched |

## Verification
A bit counter that is off by one shifts the CRC, end-bit and token windows. On writes the first misplaced CRC bit shows on datOut within one clock. On reads it shows as a wrong word or a low readCrcOk when done arrives. A CRC register that is wrong or not restarted shows on datOut within the first CRC clock of the affected block. A block counter or busy-wait fault shows as done arriving early, late or while DAT0 is still held low. A lane mapping fault shows in datOe on the first driven clock, or as scrambled read words.

// File: rtl/sd_block_mover_pkg.sv
package sd_block_mover_pkg;

  localparam int LANES = 4;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  typedef enum logic [3:0] {
    ST_IDLE, ST_GAP, ST_WSTART, ST_DATA, ST_CRC, ST_WEND,
    ST_TOKWAIT, ST_TOKEN, ST_BUSY, ST_RSTART, ST_REND
  } stateT;

  typedef enum logic [1:0] { OUT_START, OUT_DATA, OUT_CRC, OUT_END } outSelT;

  typedef struct packed {
    logic   clearStatus;
    logic   clearCrc;
    logic   loadWord;
    logic   shiftData;
    logic   crcShift;
    logic   crcCheck;
    logic   wordEnd;
    logic   grabToken;
    logic   judgeToken;
    logic   finish;
    logic   drive;
    outSelT outSel;
  } strobeT;

  function automatic logic [CRC_W-1:0] crcStep(logic [CRC_W-1:0] c, logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  function automatic logic [LANES-1:0] swapLanes(logic [LANES-1:0] v, logic en);
    return en ? {v[3], v[2], v[0], v[1]} : v;
  endfunction

endpackage

// File: rtl/sd_block_mover_ctrl.sv
module sd_block_mover_ctrl
  import sd_block_mover_pkg::*;
#(
  parameter int BITS_W = 14,
  parameter int CNT_W  = 8,
  parameter int GAP_W  = 6,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isWrite,
  input  logic              wideBus,
  input  logic [CNT_W-1:0]  blockCountM1,
  input  logic [BITS_W-1:0] blockBits,
  input  logic [GAP_W-1:0]  gapClocks,
  input  logic              startSeen,
  input  logic              dat0,
  output strobeT            stb,
  output logic              busy,
  output logic              done
);
  localparam int CRC_PAD    = CRC_W - 1;
  localparam int WIDE_SH    = $clog2(WORD_W / LANES);
  localparam int NARROW_SH  = $clog2(WORD_W);
  localparam int TOKEN_LAST = 3;

  stateT             state;
  logic [BITS_W-1:0] cnt;
  logic [CNT_W-1:0]  blkLeft;
  logic [BITS_W-1:0] dataLast;
  logic              wordEnd;
  logic              lastBlk;

  assign dataLast = wideBus ? (((blockBits - BITS_W'(LANES * CRC_PAD)) >> 2) - BITS_W'(1))
                            : (blockBits - BITS_W'(CRC_PAD + 1));
  assign wordEnd  = wideBus ? (&cnt[WIDE_SH-1:0]) : (&cnt[NARROW_SH-1:0]);
  assign lastBlk  = (blkLeft == '0);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    stb = '0;
    case (state)
      ST_IDLE: begin
        stb.clearStatus = start;
        stb.clearCrc    = start;
      end
      ST_WSTART: begin
        stb.drive    = 1'b1;
        stb.outSel   = OUT_START;
        stb.loadWord = 1'b1;
        stb.clearCrc = 1'b1;
      end
      ST_DATA: begin
        stb.shiftData = 1'b1;
        stb.wordEnd   = wordEnd;
        stb.drive     = isWrite;
        stb.outSel    = OUT_DATA;
        stb.loadWord  = isWrite && wordEnd && (cnt != dataLast);
      end
      ST_CRC: begin
        stb.crcShift = 1'b1;
        stb.drive    = isWrite;
        stb.outSel   = OUT_CRC;
        stb.crcCheck = !isWrite;
      end
      ST_WEND: begin
        stb.drive  = 1'b1;
        stb.outSel = OUT_END;
      end
      ST_TOKEN: begin
        stb.grabToken  = (cnt < BITS_W'(TOKEN_LAST));
        stb.judgeToken = (cnt == BITS_W'(TOKEN_LAST));
      end
      ST_BUSY:   stb.finish   = dat0 && lastBlk;
      ST_RSTART: stb.clearCrc = 1'b1;
      ST_REND:   stb.finish   = lastBlk;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      blkLeft <= '0;
      done    <= 1'b0;
    end else begin
      done <= stb.finish;
      case (state)
        ST_IDLE: if (start) begin
          blkLeft <= blockCountM1;
          cnt     <= '0;
          if (!isWrite)              state <= ST_RSTART;
          else if (gapClocks == '0)  state <= ST_WSTART;
          else                       state <= ST_GAP;
        end
        ST_GAP: begin
          if (cnt[GAP_W-1:0] + 1'b1 == gapClocks) state <= ST_WSTART;
          else cnt <= cnt + 1'b1;
        end
        ST_WSTART: begin
          cnt   <= '0;
          state <= ST_DATA;
        end
        ST_DATA: begin
          if (cnt == dataLast) begin
            cnt   <= '0;
            state <= ST_CRC;
          end else cnt <= cnt + 1'b1;
        end
        ST_CRC: begin
          if (cnt == BITS_W'(CRC_W - 1)) begin
            cnt   <= '0;
            state <= isWrite ? ST_WEND : ST_REND;
          end else cnt <= cnt + 1'b1;
        end
        ST_WEND: state <= ST_TOKWAIT;
        ST_TOKWAIT: if (!dat0) begin
          cnt   <= '0;
          state <= ST_TOKEN;
        end
        ST_TOKEN: begin
          if (cnt == BITS_W'(TOKEN_LAST)) state <= ST_BUSY;
          else cnt <= cnt + 1'b1;
        end
        ST_BUSY: if (dat0) begin
          cnt <= '0;
          if (lastBlk) state <= ST_IDLE;
          else begin
            blkLeft <= blkLeft - 1'b1;
            state   <= (gapClocks == '0) ? ST_WSTART : ST_GAP;
          end
        end
        ST_RSTART: if (startSeen) begin
          cnt   <= '0;
          state <= ST_DATA;
        end
        ST_REND: begin
          if (lastBlk) state <= ST_IDLE;
          else begin
            blkLeft <= blkLeft - 1'b1;
            state   <= ST_RSTART;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_block_mover_dp.sv
module sd_block_mover_dp
  import sd_block_mover_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int TOK_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic              isWrite,
  input  logic              wideBus,
  input  logic              laneSwap,
  input  logic [TOK_W-1:0]  expectToken,
  input  logic [LANES-1:0]  datIn,
  output logic [LANES-1:0]  datOut,
  output logic [LANES-1:0]  datOe,
  input  logic [WORD_W-1:0] wordIn,
  output logic              wordInReady,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordOutValid,
  output logic              startSeen,
  output logic              dat0,
  output logic              readCrcOk,
  output logic              writeCrcOk
);
  logic [LANES-1:0]  logicIn, txBits, logicOut, laneMask, crcTop, mismatch;
  logic [WORD_W-1:0] txShift, rxWord;
  logic [TOK_W-1:0]  tokenShift;
  logic              sawBad, rxValid;

  assign logicIn   = swapLanes(datIn, laneSwap);
  assign laneMask  = wideBus ? '1 : LANES'(1);
  assign txBits    = wideBus ? txShift[WORD_W-1 -: LANES] : {{(LANES-1){1'b1}}, txShift[WORD_W-1]};
  assign startSeen = wideBus ? (logicIn == '0) : !logicIn[0];
  assign dat0      = logicIn[0];

  always_comb begin
    case (stb.outSel)
      OUT_START: logicOut = '0;
      OUT_DATA:  logicOut = txBits;
      OUT_CRC:   logicOut = crcTop;
      default:   logicOut = '1;
    endcase
  end

  assign datOut       = swapLanes(logicOut, laneSwap);
  assign datOe        = swapLanes(stb.drive ? laneMask : '0, laneSwap);
  assign wordInReady  = stb.loadWord;
  assign wordOut      = rxWord;
  assign wordOutValid = rxValid;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [CRC_W-1:0] crc;
    logic             feed;
    assign feed = isWrite ? txBits[i] : logicIn[i];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              crc <= '0;
      else if (stb.clearCrc)  crc <= '0;
      else if (stb.shiftData) crc <= crcStep(crc, feed);
      else if (stb.crcShift)  crc <= {crc[CRC_W-2:0], 1'b0};
    end
    assign crcTop[i]   = crc[CRC_W-1];
    assign mismatch[i] = stb.crcCheck && laneMask[i] && (logicIn[i] != crc[CRC_W-1]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift    <= '0;
      rxWord     <= '0;
      rxValid    <= 1'b0;
      tokenShift <= '0;
      sawBad     <= 1'b0;
      readCrcOk  <= 1'b0;
      writeCrcOk <= 1'b0;
    end else begin
      rxValid <= stb.shiftData && !isWrite && stb.wordEnd;
      if (stb.loadWord) txShift <= wordIn;
      else if (stb.shiftData && isWrite)
        txShift <= wideBus ? {txShift[WORD_W-LANES-1:0], {LANES{1'b0}}} : {txShift[WORD_W-2:0], 1'b0};
      if (stb.shiftData && !isWrite)
        rxWord <= wideBus ? {rxWord[WORD_W-LANES-1:0], logicIn} : {rxWord[WORD_W-2:0], logicIn[0]};
      if (stb.grabToken) tokenShift <= {tokenShift[TOK_W-2:0], logicIn[0]};
      if (stb.clearStatus) begin
        sawBad     <= 1'b0;
        readCrcOk  <= 1'b0;
        writeCrcOk <= 1'b0;
      end else begin
        if ((|mismatch) || (stb.judgeToken && tokenShift != expectToken)) sawBad <= 1'b1;
        if (stb.finish) begin
          readCrcOk  <= !isWrite && !sawBad;
          writeCrcOk <= isWrite && !sawBad;
        end
      end
    end
  end
endmodule

// File: rtl/sd_block_mover.sv
module sd_block_mover
  import sd_block_mover_pkg::*;
#(
  parameter int BITS_W = 14,
  parameter int CNT_W  = 8,
  parameter int GAP_W  = 6,
  parameter int TOK_W  = 3,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isWrite,
  input  logic              wideBus,
  input  logic              laneSwap,
  input  logic [CNT_W-1:0]  blockCountM1,
  input  logic [BITS_W-1:0] blockBits,
  input  logic [GAP_W-1:0]  gapClocks,
  input  logic [TOK_W-1:0]  expectToken,
  input  logic [3:0]        datIn,
  output logic [3:0]        datOut,
  output logic [3:0]        datOe,
  input  logic [WORD_W-1:0] wordIn,
  output logic              wordInReady,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordOutValid,
  output logic              busy,
  output logic              done,
  output logic              readCrcOk,
  output logic              writeCrcOk
);
  strobeT stb;
  logic   startSeen, dat0;

  sd_block_mover_ctrl #(.BITS_W(BITS_W), .CNT_W(CNT_W), .GAP_W(GAP_W), .WORD_W(WORD_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .isWrite(isWrite), .wideBus(wideBus),
    .blockCountM1(blockCountM1), .blockBits(blockBits), .gapClocks(gapClocks),
    .startSeen(startSeen), .dat0(dat0), .stb(stb), .busy(busy), .done(done)
  );

  sd_block_mover_dp #(.WORD_W(WORD_W), .TOK_W(TOK_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .isWrite(isWrite), .wideBus(wideBus),
    .laneSwap(laneSwap), .expectToken(expectToken), .datIn(datIn), .datOut(datOut),
    .datOe(datOe), .wordIn(wordIn), .wordInReady(wordInReady), .wordOut(wordOut),
    .wordOutValid(wordOutValid), .startSeen(startSeen), .dat0(dat0),
    .readCrcOk(readCrcOk), .writeCrcOk(writeCrcOk)
  );
endmodule

// File: rtl/sd_block_mover_chk.sv
module sd_block_mover_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic       readCrcOk,
  input logic       writeCrcOk,
  input logic       wordOutValid,
  input logic       wordInReady,
  input logic [3:0] datOe
);
  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  assert_done_idle_R12:   assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);
  assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rstN) !busy |-> datOe == 4'h0);
  assert_one_flag_R7:     assert property (@(posedge clk) disable iff (!rstN) !(readCrcOk && writeCrcOk));
  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rstN) $rose(busy) |-> !readCrcOk && !writeCrcOk);
  assert_ready_drive_R13: assert property (@(posedge clk) disable iff (!rstN) wordInReady |-> busy && datOe != 4'h0);
  assert_rx_quiet_R13:    assert property (@(posedge clk) disable iff (!rstN) wordOutValid |-> datOe == 4'h0);
  assert_lane_count_R4:   assert property (@(posedge clk) disable iff (!rstN) $countones(datOe) != 2 && $countones(datOe) != 3);
endmodule

bind sd_block_mover sd_block_mover_chk chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .readCrcOk(readCrcOk),
  .writeCrcOk(writeCrcOk), .wordOutValid(wordOutValid), .wordInReady(wordInReady), .datOe(datOe)
);

// File: tb/sd_block_mover_tb_top.sv
module sd_block_mover_tb_top;
  logic        clk = 1'b0, rstN = 1'b0, start = 1'b0, isWrite = 1'b0, wideBus = 1'b0, laneSwap = 1'b0;
  logic [7:0]  blockCountM1 = '0;
  logic [13:0] blockBits = '0;
  logic [5:0]  gapClocks = '0;
  logic [2:0]  expectToken = 3'b010;
  logic [3:0]  datIn = 4'hF;
  logic [31:0] wordIn = '0;
  logic [3:0]  datOut, datOe;
  logic [31:0] wordOut;
  logic        wordInReady, wordOutValid, busy, done, readCrcOk, writeCrcOk;

  int total = 0, bad = 0;
  int txIdx = 0, rxCount = 0, curWpb = 1, curSeed = 0;
  bit consumePend = 0;
  logic [31:0] rxWords [512];

  always #10 clk = ~clk;

  sd_block_mover dut_i (
    .clk(clk), .rstN(rstN), .start(start), .isWrite(isWrite), .wideBus(wideBus), .laneSwap(laneSwap),
    .blockCountM1(blockCountM1), .blockBits(blockBits), .gapClocks(gapClocks), .expectToken(expectToken),
    .datIn(datIn), .datOut(datOut), .datOe(datOe), .wordIn(wordIn), .wordInReady(wordInReady),
    .wordOut(wordOut), .wordOutValid(wordOutValid), .busy(busy), .done(done),
    .readCrcOk(readCrcOk), .writeCrcOk(writeCrcOk)
  );

  typedef struct packed {
    logic       wr;
    logic       wd;
    logic       sw;
    logic [7:0] nBlk;
    logic [7:0] wpb;
    logic [5:0] gap;
    logic       badOne;
  } vecT;

  localparam vecT VECS [7] = '{
    '{1'b0, 1'b0, 1'b0, 8'd1, 8'd2, 6'd0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 8'd3, 8'd4, 6'd0, 1'b0},
    '{1'b0, 1'b1, 1'b1, 8'd2, 8'd2, 6'd0, 1'b1},
    '{1'b1, 1'b0, 1'b0, 8'd1, 8'd2, 6'd2, 1'b0},
    '{1'b1, 1'b1, 1'b0, 8'd2, 8'd4, 6'd0, 1'b0},
    '{1'b1, 1'b1, 1'b1, 8'd2, 8'd2, 6'd5, 1'b1},
    '{1'b0, 1'b0, 1'b1, 8'd1, 8'd1, 6'd0, 1'b0}
  };

  function automatic logic [31:0] wordAt(int idx, int seed);
    logic [31:0] v;
    v = 32'(idx + 1 + seed * 4096);
    return (v * 32'h9E3779B9) ^ 32'h0F1E2D3C;
  endfunction

  function automatic logic [15:0] crcNext(logic [15:0] c, logic b);
    logic [15:0] s;
    s = c << 1;
    if (b != c[15]) s = s ^ 16'h1021;
    return s;
  endfunction

  function automatic logic [3:0] mapLanes(logic [3:0] v);
    return laneSwap ? {v[3], v[2], v[0], v[1]} : v;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(negedge clk) begin
    if (consumePend) txIdx++;
    consumePend = wordInReady;
    wordIn = wordAt(txIdx, curSeed);
  end

  always @(negedge clk) begin
    if (wordOutValid) begin
      if (rxCount < 512) rxWords[rxCount] = wordOut;
      rxCount++;
    end
  end

  task automatic laneBits(logic [31:0] v, int k, output logic [3:0] lanes);
    if (wideBus) lanes = v[31 - 4 * k -: 4];
    else lanes = {3'b111, v[31 - k]};
  endtask

  task automatic runRead(logic wd, logic sw, int nBlk, int wpb, bit corrupt, int seed);
    int clocksPerWord;
    logic [15:0] c [4];
    logic [3:0] lanes, mask;
    int wordErrs;
    isWrite = 0; wideBus = wd; laneSwap = sw; curWpb = wpb; curSeed = seed;
    blockCountM1 = 8'(nBlk - 1);
    blockBits = 14'(wpb * 32 + 15 * (wd ? 4 : 1));
    clocksPerWord = wd ? 8 : 32;
    mask = wd ? 4'hF : 4'h1;
    datIn = 4'hF;
    @(negedge clk); rxCount = 0;
    start = 1; @(negedge clk); start = 0;
    for (int b = 0; b < nBlk; b++) begin
      datIn = mapLanes(4'hF); @(negedge clk);
      datIn = mapLanes(wd ? 4'hE : 4'h1); @(negedge clk);  // R5 not a start pattern
      datIn = mapLanes(wd ? 4'h0 : 4'hE); @(negedge clk);
      for (int i = 0; i < 4; i++) c[i] = '0;
      for (int w = 0; w < wpb; w++) begin
        for (int k = 0; k < clocksPerWord; k++) begin
          laneBits(wordAt(b * wpb + w, seed), k, lanes);
          for (int i = 0; i < 4; i++) c[i] = crcNext(c[i], lanes[i]);
          datIn = mapLanes(lanes); @(negedge clk);
        end
      end
      for (int j = 0; j < 16; j++) begin
        for (int i = 0; i < 4; i++) lanes[i] = mask[i] ? c[i][15 - j] : 1'b1;
        if (corrupt && b == 0 && j == 5) lanes[0] = ~lanes[0];
        datIn = mapLanes(lanes); @(negedge clk);
      end
      datIn = mapLanes(4'hF); @(negedge clk);
    end
    check(done == 1'b1 && busy == 1'b0, "R12", "read done pulse/busy", {30'b0, done, busy}, 32'h2);
    check(readCrcOk == !corrupt, "R7", "readCrcOk", 32'(readCrcOk), 32'(!corrupt));
    check(writeCrcOk == 1'b0, "R7", "writeCrcOk after read", 32'(writeCrcOk), 0);
    check(rxCount == nBlk * wpb, "R2", "received word count", 32'(rxCount), 32'(nBlk * wpb));
    wordErrs = 0;
    for (int n = 0; n < nBlk * wpb && n < 512; n++)
      if (rxWords[n] !== wordAt(n, seed)) wordErrs++;
    check(wordErrs == 0, sw ? "R11" : "R4", "read word mismatches", 32'(wordErrs), 0);
    @(negedge clk);
    check(done == 1'b0, "R12", "done drops", 32'(done), 0);
  endtask

  task automatic runWrite(logic wd, logic sw, int nBlk, int wpb, int gap, int badBlk, int seed);
    int clocksPerWord, zeros, dataErrs, crcErrs;
    logic [15:0] c [4];
    logic [3:0] lanes, got, mask;
    logic [2:0] tok;
    isWrite = 1; wideBus = wd; laneSwap = sw; curWpb = wpb; curSeed = seed;
    blockCountM1 = 8'(nBlk - 1);
    blockBits = 14'(wpb * 32 + 15 * (wd ? 4 : 1));
    gapClocks = 6'(gap);
    clocksPerWord = wd ? 8 : 32;
    mask = wd ? 4'hF : 4'h1;
    datIn = 4'hF;
    @(negedge clk); txIdx = 0; consumePend = 0;
    @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    dataErrs = 0; crcErrs = 0;
    for (int b = 0; b < nBlk; b++) begin
      zeros = 0;
      while (datOe == 4'h0 && zeros < 100) begin zeros++; @(negedge clk); end
      check(zeros == gap, "R8", "gap clocks", 32'(zeros), 32'(gap));
      check(datOe == mapLanes(mask), "R4/R11", "lane enables", 32'(datOe), 32'(mapLanes(mask)));
      got = mapLanes(datOut);
      check((got & mask) == 4'h0, "R8", "start bit", 32'(got & mask), 0);
      @(negedge clk);
      for (int i = 0; i < 4; i++) c[i] = '0;
      for (int w = 0; w < wpb; w++) begin
        for (int k = 0; k < clocksPerWord; k++) begin
          laneBits(wordAt(b * wpb + w, seed), k, lanes);
          for (int i = 0; i < 4; i++) c[i] = crcNext(c[i], lanes[i]);
          got = mapLanes(datOut);
          if ((got & mask) != (lanes & mask)) dataErrs++;
          @(negedge clk);
        end
      end
      for (int j = 0; j < 16; j++) begin
        got = mapLanes(datOut);
        for (int i = 0; i < 4; i++) if (mask[i] && got[i] != c[i][15 - j]) crcErrs++;
        @(negedge clk);
      end
      got = mapLanes(datOut);
      check((got & mask) == mask, "R3", "end bit after 16 CRC clocks", 32'(got & mask), 32'(mask));
      @(negedge clk);
      check(datOe == 4'h0, "R9", "lines released for token", 32'(datOe), 0);
      tok = (b == badBlk) ? 3'b101 : 3'b010;
      datIn = mapLanes(4'hE); @(negedge clk);
      for (int t = 2; t >= 0; t--) begin datIn = mapLanes({3'b111, tok[t]}); @(negedge clk); end
      datIn = mapLanes(4'hF); @(negedge clk);
      datIn = mapLanes(4'hE); @(negedge clk);
      datIn = mapLanes(4'hE); @(negedge clk);
      datIn = mapLanes(4'hE); @(negedge clk);
      check(busy == 1'b1 && done == 1'b0, "R10", "holds while DAT0 low", {30'b0, busy, done}, 32'h2);
      datIn = mapLanes(4'hF); @(negedge clk);
    end
    check(done == 1'b1 && busy == 1'b0, "R12", "write done pulse/busy", {30'b0, done, busy}, 32'h2);
    check(writeCrcOk == (badBlk < 0), "R9", "writeCrcOk", 32'(writeCrcOk), 32'(badBlk < 0));
    check(readCrcOk == 1'b0, "R7", "readCrcOk after write", 32'(readCrcOk), 0);
    check(dataErrs == 0, sw ? "R11" : "R4", "written data bit errors", 32'(dataErrs), 0);
    check(crcErrs == 0, "R6", "written CRC bit errors", 32'(crcErrs), 0);
    check(txIdx == nBlk * wpb, "R13", "words taken", 32'(txIdx), 32'(nBlk * wpb));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R12 watchdog act=%0d exp=%0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({busy, done, datOe, wordOutValid, wordInReady, readCrcOk, writeCrcOk} == '0, "R1",
          "state in reset", 32'({busy, done, datOe, wordOutValid, wordInReady, readCrcOk, writeCrcOk}), 0);
    rstN = 1;
    @(negedge clk);
    check({busy, done, datOe, wordOutValid, wordInReady, readCrcOk, writeCrcOk} == '0, "R1",
          "state after reset", 32'({busy, done, datOe, wordOutValid, wordInReady, readCrcOk, writeCrcOk}), 0);
    for (int v = 0; v < 7; v++) begin
      if (VECS[v].wr)
        runWrite(VECS[v].wd, VECS[v].sw, int'(VECS[v].nBlk), int'(VECS[v].wpb), int'(VECS[v].gap),
                 VECS[v].badOne ? int'(VECS[v].nBlk) - 1 : -1, v);
      else
        runRead(VECS[v].wd, VECS[v].sw, int'(VECS[v].nBlk), int'(VECS[v].wpb), VECS[v].badOne, v);
      repeat (2) @(negedge clk);
    end
    // R2: maximum block count field gives 256 blocks
    runRead(1'b1, 1'b0, 256, 1, 1'b0, 9);
    // R13: single 1-bit write block with one word and a long gap
    runWrite(1'b0, 1'b1, 1, 1, 63, -1, 11);
    // R5: a lone partial start pattern must not begin a read; bus stays idle
    runRead(1'b1, 1'b1, 1, 1, 1'b0, 12);
    summary();
    $finish;
  end
endmodule